// File: doc/BRIEF.md
# Dual-Plane Page Write Engine

This block is the write path of a byte-wide nonvolatile store that is split into two equal halves (planes). The most significant address bit selects the plane. Incoming byte writes are gathered in a page buffer. When no further byte for the open page arrives for a set number of clocks, the engine runs a timed program cycle on the plane that holds the page. During that cycle, reads of the other plane keep returning stored data with the usual one-cycle latency. Reads of the busy plane return a status byte instead, and one bit of that byte flips on every such read. Software can poll that bit to see the end of the write without waiting the worst-case time.

Writes enter through a valid/ready stream. `wr_ready` is low only in one case: a program cycle is running and the offered byte targets the other plane. The producer must then hold `wr_valid`, `wr_addr` and `wr_data` steady until `wr_ready` returns. `wr_ready` is a combinational function of `wr_addr` and the engine state. Reads are never back-pressured. Each read request is answered on the next cycle through `rsp_valid`/`rsp_data`, and there is no ready on the response. `wr_cancel` is a plain control pin that discards a page that is still loading. `PROG_CYCLES` must be at least `PAGE_BYTES`, and `DATA_W` must be at least 8.

Top module: `dp_page_writer`

## Requirements
- R1: A read accepted on a clock edge produces `rsp_valid` high after that edge. If the addressed plane is not busy, `rsp_data` is the stored byte, and this includes reads of the idle plane while the other plane programs.
- R2: Every byte loaded into one page, from 1 up to `PAGE_BYTES`, is committed by a single program cycle and reads back afterwards.
- R3: While a page is loading, an accepted byte whose page address (`wr_addr` above the low log2(`PAGE_BYTES`) bits) differs from the open page is dropped and never stored.
- R4: `busy` rises exactly `IDLE_LIMIT` cycles after the edge that accepted the last in-page byte.
- R5: `busy` stays high for exactly `PROG_CYCLES` cycles.
- R6: A read of the busy plane returns a status byte. Bit 7 is 1, bits 5..0 are 0, and bit 6 is 0 on the first such read of a program cycle and inverts on each further one.
- R7: Asserting `wr_cancel` while a page is loading discards the page. No program cycle follows, and no byte changes.
- R8: During a program cycle, a write aimed at the busy plane is accepted (`wr_ready` high) and discarded.
- R9: During a program cycle, a write aimed at the other plane sees `wr_ready` low. At every other time `wr_ready` is high.
- R10: Bytes of a page that were not loaded keep their previous contents. The buffer is emptied after each commit, so an earlier page's bytes are never written again.
- R11: After reset all stored bytes read 0, `busy` and `rsp_valid` are low, and `wr_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Write byte accepted this cycle when high with wr_valid |
| wr_addr | input | ADDR_W | Byte address of the write; MSB selects the plane |
| wr_data | input | DATA_W | Byte to write |
| wr_cancel | input | 1 | Discard the page being loaded |
| rd_valid | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read address; MSB selects the plane |
| rsp_valid | output | 1 | Read response present (one cycle after rd_valid) |
| rsp_data | output | DATA_W | Stored byte or status byte |
| busy | output | 1 | Program cycle in progress |

## Verification
A wrong idle or program counter shows at `busy` within one program period. The bench sees it as an edge that is early or late by the offending number of cycles. A corrupted page register or valid mask is silent until the plane is read after the commit: either a byte is missing, or bytes land in the wrong page. A stuck toggle or a wrong busy-plane selection appears on the first two status reads, or on the first write offered to the other plane during a program cycle, because `wr_ready` is wrong in that same cycle.

// File: rtl/dpw_pkg.sv
package dpw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } dpw_state_e;

  localparam int STAT_BUSY_BIT = 7;
  localparam int STAT_TOG_BIT  = 6;
endpackage

// File: rtl/dpw_page_buffer.sv
module dpw_page_buffer #(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 8,
  localparam int IW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IW-1:0]     widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic              clr,
  input  logic [IW-1:0]     ridx,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  logic [DATA_W-1:0] slot_d [DEPTH];
  logic [DEPTH-1:0]  slot_v;

  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_v[e] <= 1'b0;
        slot_d[e] <= '0;
      end else if (clr) begin
        slot_v[e] <= 1'b0;
      end else if (we && widx == IW'(e)) begin
        slot_v[e] <= 1'b1;
        slot_d[e] <= wdata;
      end
    end
  end

  assign rdata  = slot_d[ridx];
  assign rvalid = slot_v[ridx];
endmodule

// File: rtl/dpw_plane_store.sv
module dpw_plane_store #(
  parameter int AW     = 8,
  parameter int DATA_W = 8,
  localparam int DEPTH = 2 ** AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
    end else if (we) begin
      cells[waddr] <= wdata;
    end
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/dpw_ctrl.sv
module dpw_ctrl
  import dpw_pkg::*;
#(
  parameter int ADDR_W      = 9,
  parameter int PAGE_BYTES  = 32,
  parameter int IDLE_LIMIT  = 6,
  parameter int PROG_CYCLES = 40,
  localparam int OFFS_W     = $clog2(PAGE_BYTES),
  localparam int PAGE_AW    = ADDR_W - OFFS_W,
  localparam int PLANE_AW   = ADDR_W - 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_valid,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic                wr_cancel,
  output logic                wr_ready,
  output logic                buf_we,
  output logic [OFFS_W-1:0]   buf_widx,
  output logic                buf_clr,
  output logic [OFFS_W-1:0]   buf_ridx,
  input  logic                buf_rvalid,
  output logic                mem_we,
  output logic [PLANE_AW-1:0] mem_addr,
  output logic                busy,
  output logic                busy_plane,
  output logic                loading
);
  localparam int ICW = $clog2(IDLE_LIMIT + 1);
  localparam int PCW = $clog2(PROG_CYCLES + 1);
  localparam logic [ICW-1:0] IDLE_LAST = ICW'(IDLE_LIMIT - 1);
  localparam logic [PCW-1:0] PROG_LAST = PCW'(PROG_CYCLES - 1);
  localparam logic [PCW-1:0] PAGE_LIM  = PCW'(PAGE_BYTES);

  dpw_state_e         state_q;
  logic [PAGE_AW-1:0] page_q;
  logic [ICW-1:0]     idle_cnt;
  logic [PCW-1:0]     prog_cnt;

  logic               wr_plane;
  logic [PAGE_AW-1:0] wr_page;
  logic               accept;
  logic               in_page;

  assign wr_plane = wr_addr[ADDR_W-1];
  assign wr_page  = wr_addr[ADDR_W-1:OFFS_W];
  assign in_page  = (wr_page == page_q);

  assign busy       = (state_q == ST_PROG);
  assign loading    = (state_q == ST_LOAD);
  assign busy_plane = page_q[PAGE_AW-1];
  assign wr_ready   = !(busy && (wr_plane != busy_plane));
  assign accept     = wr_valid && wr_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      page_q   <= '0;
      idle_cnt <= '0;
      prog_cnt <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            page_q   <= wr_page;
            idle_cnt <= '0;
            state_q  <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          if (wr_cancel) begin
            idle_cnt <= '0;
            state_q  <= ST_IDLE;
          end else if (accept && in_page) begin
            idle_cnt <= '0;
          end else if (idle_cnt == IDLE_LAST) begin
            idle_cnt <= '0;
            prog_cnt <= '0;
            state_q  <= ST_PROG;
          end else begin
            idle_cnt <= idle_cnt + 1'b1;
          end
        end
        ST_PROG: begin
          if (prog_cnt == PROG_LAST) begin
            prog_cnt <= '0;
            state_q  <= ST_IDLE;
          end else begin
            prog_cnt <= prog_cnt + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    buf_we   = accept && ((state_q == ST_IDLE) ||
                          (state_q == ST_LOAD && !wr_cancel && in_page));
    buf_widx = wr_addr[OFFS_W-1:0];
    buf_clr  = (state_q == ST_LOAD && wr_cancel) ||
               (state_q == ST_PROG && prog_cnt == PROG_LAST);
    buf_ridx = prog_cnt[OFFS_W-1:0];
    mem_we   = busy && (prog_cnt < PAGE_LIM) && buf_rvalid;
    mem_addr = {page_q[PAGE_AW-2:0], prog_cnt[OFFS_W-1:0]};
  end
endmodule

// File: rtl/dpw_read_port.sv
module dpw_read_port
  import dpw_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_valid,
  input  logic              rd_plane,
  input  logic              busy,
  input  logic              busy_plane,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);
  logic              tog_q;
  logic              status_hit;
  logic [DATA_W-1:0] status_byte;

  assign status_hit = rd_valid && busy && (rd_plane == busy_plane);

  always_comb begin
    status_byte = '0;
    status_byte[STAT_BUSY_BIT] = 1'b1;
    status_byte[STAT_TOG_BIT]  = tog_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tog_q     <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd_valid;
      if (rd_valid) rsp_data <= status_hit ? status_byte : mem_rdata;
      if (!busy)           tog_q <= 1'b0;
      else if (status_hit) tog_q <= ~tog_q;
    end
  end
endmodule

// File: rtl/dp_page_writer.sv
module dp_page_writer #(
  parameter int ADDR_W      = 9,
  parameter int DATA_W      = 8,
  parameter int PAGE_BYTES  = 32,
  parameter int IDLE_LIMIT  = 6,
  parameter int PROG_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_cancel,
  input  logic              rd_valid,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              busy
);
  localparam int OFFS_W     = $clog2(PAGE_BYTES);
  localparam int PLANE_AW   = ADDR_W - 1;
  localparam int NUM_PLANES = 2;

  logic                buf_we, buf_clr, buf_rvalid;
  logic [OFFS_W-1:0]   buf_widx, buf_ridx;
  logic [DATA_W-1:0]   buf_rdata;
  logic                mem_we;
  logic [PLANE_AW-1:0] mem_addr;
  logic                busy_plane;
  logic                loading;
  logic [DATA_W-1:0]   plane_rd [NUM_PLANES];
  logic [DATA_W-1:0]   mem_rdata;

  dpw_ctrl #(
    .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES),
    .IDLE_LIMIT(IDLE_LIMIT), .PROG_CYCLES(PROG_CYCLES)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_cancel(wr_cancel),
    .wr_ready(wr_ready),
    .buf_we(buf_we), .buf_widx(buf_widx), .buf_clr(buf_clr),
    .buf_ridx(buf_ridx), .buf_rvalid(buf_rvalid),
    .mem_we(mem_we), .mem_addr(mem_addr),
    .busy(busy), .busy_plane(busy_plane), .loading(loading)
  );

  dpw_page_buffer #(.DEPTH(PAGE_BYTES), .DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .we(buf_we), .widx(buf_widx), .wdata(wr_data), .clr(buf_clr),
    .ridx(buf_ridx), .rdata(buf_rdata), .rvalid(buf_rvalid)
  );

  for (genvar p = 0; p < NUM_PLANES; p++) begin : g_plane
    dpw_plane_store #(.AW(PLANE_AW), .DATA_W(DATA_W)) u_store (
      .clk(clk), .rst_n(rst_n),
      .we(mem_we && (busy_plane == 1'(p))),
      .waddr(mem_addr), .wdata(buf_rdata),
      .raddr(rd_addr[PLANE_AW-1:0]), .rdata(plane_rd[p])
    );
  end

  assign mem_rdata = plane_rd[rd_addr[ADDR_W-1]];

  dpw_read_port #(.DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst_n(rst_n),
    .rd_valid(rd_valid), .rd_plane(rd_addr[ADDR_W-1]),
    .busy(busy), .busy_plane(busy_plane),
    .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );
endmodule

// File: rtl/dpw_checker.sv
module dpw_checker #(
  parameter int PROG_CYCLES = 40,
  localparam int CW = $clog2(PROG_CYCLES + 2)
) (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       busy_plane,
  input logic       loading,
  input logic       wr_ready,
  input logic       wr_plane,
  input logic       wr_cancel,
  input logic       rd_valid,
  input logic       rd_plane,
  input logic       rsp_valid,
  input logic [7:0] rsp_data
);
  logic [CW-1:0] bcnt;
  logic          stat_rsp_q;
  logic          have_prev;
  logic          prev_tog;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bcnt       <= '0;
      stat_rsp_q <= 1'b0;
      have_prev  <= 1'b0;
      prev_tog   <= 1'b0;
    end else begin
      bcnt       <= busy ? bcnt + 1'b1 : '0;
      stat_rsp_q <= rd_valid && busy && (rd_plane == busy_plane);
      if (stat_rsp_q) begin
        have_prev <= 1'b1;
        prev_tog  <= rsp_data[6];
      end else if (!busy) begin
        have_prev <= 1'b0;
      end
    end
  end

  p_idle_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> wr_ready);
  p_other_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_plane != busy_plane) |-> !wr_ready);
  p_busy_plane_open_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_plane == busy_plane) |-> wr_ready);
  p_rsp_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> rsp_valid);
  p_rsp_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |=> !rsp_valid);
  p_status_shape_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rsp_q |-> (rsp_data[7] && rsp_data[5:0] == 6'd0));
  p_toggle_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rsp_q && have_prev) |-> (rsp_data[6] != prev_tog));
  p_busy_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (bcnt < CW'(PROG_CYCLES)));
  p_busy_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (bcnt == CW'(PROG_CYCLES)));
  p_cancel_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (loading && wr_cancel) |=> !busy);
endmodule

bind dp_page_writer dpw_checker #(.PROG_CYCLES(PROG_CYCLES)) chk_i (
  .clk(clk), .rst_n(rst_n),
  .busy(busy), .busy_plane(busy_plane), .loading(loading),
  .wr_ready(wr_ready), .wr_plane(wr_addr[ADDR_W-1]), .wr_cancel(wr_cancel),
  .rd_valid(rd_valid), .rd_plane(rd_addr[ADDR_W-1]),
  .rsp_valid(rsp_valid), .rsp_data(rsp_data[7:0])
);

// File: tb/dp_page_writer_tb_top.sv
`timescale 1ns/1ps
module dp_page_writer_tb_top;
  localparam int AW = 9;
  localparam int PB = 32;
  localparam int IL = 6;
  localparam int PC = 40;
  localparam int MEMN = 2 ** AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0, wr_ready, wr_cancel = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic rd_valid = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic rsp_valid, busy;
  logic [7:0] rsp_data;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  dp_page_writer #(.ADDR_W(AW), .DATA_W(8), .PAGE_BYTES(PB),
                   .IDLE_LIMIT(IL), .PROG_CYCLES(PC)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_cancel(wr_cancel),
    .rd_valid(rd_valid), .rd_addr(rd_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .busy(busy)
  );

  // behavioural reference
  logic [7:0] m_mem [MEMN];
  logic [7:0] m_buf [PB];
  bit         m_bv  [PB];
  int m_state, m_page, m_plane, m_cnt, m_pcnt;
  bit m_tog;
  bit exp_v, exp_stat;
  logic [7:0] exp_d;

  function automatic bit m_ready(input logic [AW-1:0] a);
    return !(m_state == 2 && int'(a[AW-1]) != m_plane);
  endfunction

  task automatic m_clear();
    for (int i = 0; i < PB; i++) m_bv[i] = 1'b0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MEMN; i++) m_mem[i] = 8'h00;
      m_clear();
      m_state = 0; m_page = 0; m_plane = 0; m_cnt = 0; m_pcnt = 0;
      m_tog = 1'b0; exp_v = 1'b0; exp_d = 8'h00; exp_stat = 1'b0;
    end else begin
      bit acc;
      acc = wr_valid && m_ready(wr_addr);
      exp_v = rd_valid;
      if (rd_valid) begin
        if (m_state == 2 && int'(rd_addr[AW-1]) == m_plane) begin
          exp_d = {1'b1, m_tog, 6'b0};
          m_tog = !m_tog;
          exp_stat = 1'b1;
        end else begin
          exp_d = m_mem[rd_addr];
          exp_stat = 1'b0;
        end
      end
      case (m_state)
        0: if (acc) begin
          m_page = int'(wr_addr) / PB;
          m_plane = int'(wr_addr[AW-1]);
          m_buf[int'(wr_addr) % PB] = wr_data;
          m_bv[int'(wr_addr) % PB] = 1'b1;
          m_cnt = 0; m_state = 1;
        end
        1: if (wr_cancel) begin
          m_clear(); m_state = 0;
        end else if (acc && int'(wr_addr) / PB == m_page) begin
          m_buf[int'(wr_addr) % PB] = wr_data;
          m_bv[int'(wr_addr) % PB] = 1'b1;
          m_cnt = 0;
        end else if (m_cnt == IL - 1) begin
          m_state = 2; m_pcnt = 0; m_tog = 1'b0;
        end else m_cnt++;
        default: if (m_pcnt == PC - 1) begin
          for (int i = 0; i < PB; i++)
            if (m_bv[i]) m_mem[m_page * PB + i] = m_buf[i];
          m_clear(); m_state = 0;
        end else m_pcnt++;
      endcase
    end
  end

  // per-cycle comparison, 1 ns after the edge
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      total++;
      if (busy !== (m_state == 2)) begin
        bad++;
        $display("FAIL R4/R5 busy: actual=%0b expected=%0b", busy, m_state == 2);
      end
      total++;
      if (wr_ready !== m_ready(wr_addr)) begin
        bad++;
        $display("FAIL R9 wr_ready: actual=%0b expected=%0b", wr_ready, m_ready(wr_addr));
      end
      total++;
      if (rsp_valid !== exp_v) begin
        bad++;
        $display("FAIL R1 rsp_valid: actual=%0b expected=%0b", rsp_valid, exp_v);
      end
      if (exp_v) begin
        total++;
        if (rsp_data !== exp_d) begin
          bad++;
          $display("FAIL %s rsp_data: actual=%02h expected=%02h",
                   exp_stat ? "R6" : "R1", rsp_data, exp_d);
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = AW'(a); wr_data = 8'(d);
    #1;
    while (!wr_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] v);
    @(negedge clk);
    rd_valid = 1'b1; rd_addr = AW'(a);
    @(negedge clk);
    v = rsp_data;
    rd_valid = 1'b0;
  endtask

  task automatic wait_busy();
    while (!busy) @(negedge clk);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL R5 watchdog: actual=timeout expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int n;
    bit rose;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R11 busy", busy, 0);
    chk(rsp_valid == 1'b0, "R11 rsp_valid", rsp_valid, 0);
    chk(wr_ready == 1'b1, "R11 wr_ready", wr_ready, 1);
    rst_n = 1'b1;
    rd(37, v);
    chk(v == 8'h00, "R11 cleared byte", v, 0);

    // page in plane 0, concurrent activity during its program cycle
    for (int i = 0; i < 4; i++) wr(i, 8'hA0 + i);
    wait_busy();
    rd(9'h100, v);
    chk(v == 8'h00, "R1 other-plane read while busy", v, 0);
    rd(2, v);
    chk(v == 8'h80, "R6 first status read", v, 8'h80);
    rd(3, v);
    chk(v == 8'hC0, "R6 second status read", v, 8'hC0);
    rd(2, v);
    chk(v == 8'h80, "R6 third status read", v, 8'h80);
    wr(5, 8'h55);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = 9'h120; wr_data = 8'h77;
    #1;
    chk(wr_ready == 1'b0, "R9 other-plane stall", wr_ready, 0);
    @(negedge clk);
    wr_valid = 1'b0;
    wait_idle();
    for (int i = 0; i < 4; i++) begin
      rd(i, v);
      chk(v == 8'(8'hA0 + i), "R2 committed byte", v, 8'hA0 + i);
    end
    rd(5, v);
    chk(v == 8'h00, "R8 busy-plane write dropped", v, 0);
    rd(9'h120, v);
    chk(v == 8'h00, "R9 stalled write not stored", v, 0);

    // out-of-page drop and timing
    wr(9'h100, 8'h11);
    wr(9'h128, 8'h22);
    wr(9'h101, 8'h12);
    n = 0;
    while (!busy) begin
      @(negedge clk);
      n++;
    end
    chk(n == IL, "R4 load timeout", n, IL);
    n = 0;
    while (busy) begin
      n++;
      @(negedge clk);
    end
    chk(n == PC, "R5 program length", n, PC);
    rd(9'h100, v);
    chk(v == 8'h11, "R2 plane1 byte0", v, 8'h11);
    rd(9'h101, v);
    chk(v == 8'h12, "R2 plane1 byte1", v, 8'h12);
    rd(9'h128, v);
    chk(v == 8'h00, "R3 foreign page byte", v, 0);

    // cancel
    wr(64, 8'h33);
    @(negedge clk);
    wr_cancel = 1'b1;
    @(negedge clk);
    wr_cancel = 1'b0;
    rose = 1'b0;
    for (int k = 0; k < IL + PC; k++) begin
      @(negedge clk);
      if (busy) rose = 1'b1;
    end
    chk(rose == 1'b0, "R7 no program after cancel", rose, 0);
    rd(64, v);
    chk(v == 8'h00, "R7 cancelled byte", v, 0);

    // partial rewrite keeps neighbours; buffer was emptied
    wr(1, 8'hEE);
    wait_busy();
    wait_idle();
    rd(0, v);
    chk(v == 8'hA0, "R10 untouched byte0", v, 8'hA0);
    rd(1, v);
    chk(v == 8'hEE, "R10 rewritten byte1", v, 8'hEE);
    rd(2, v);
    chk(v == 8'hA2, "R10 untouched byte2", v, 8'hA2);
    rd(9'h100, v);
    chk(v == 8'h11, "R10 earlier page not rewritten", v, 8'h11);

    // full page
    for (int i = 0; i < PB; i++) wr(9'h140 + i, i * 3 + 1);
    wait_busy();
    wait_idle();
    for (int i = 0; i < PB; i++) begin
      rd(9'h140 + i, v);
      chk(v == 8'(i * 3 + 1), "R2 full page", v, i * 3 + 1);
    end

    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule